// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one processor port and its memory path. It holds the reservation that lets software build atomic read-modify-write sequences without locking a shared bus. A load-linked request reads a word and records its address as a live reservation. A later store-conditional to the same address is sent to memory only if nothing has broken that reservation in the meantime. The processor is told whether the store took effect (1) or was cancelled (0), and software retries on 0.

The reservation is broken in three ways. A snooped invalidation may hit the cache block that holds the reserved address, where the block size is a parameter. A context-switch pulse breaks it. Any store-conditional also consumes it. A cancelled store-conditional produces no memory traffic at all.

The memory port works in the same cycle as the request. Read data is sampled in the request cycle. Each load-linked or store-conditional gets exactly one response on the following cycle.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous active-low reset, no reservation is held, `rsp_valid` is 0, and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: Operation encoding on `req_op` is 2'b00 idle, 2'b01 load-linked, 2'b10 store-conditional and 2'b11 reserved. A load-linked asserts `mem_rd_en` in its cycle with `mem_addr` equal to `req_addr`. One cycle later, `rsp_valid` is 1 and `rsp_data` holds the `mem_rdata` sampled in the request cycle. The load-linked records its address as a valid reservation.
- R3: A store-conditional succeeds when a reservation is valid and its address equals `req_addr` in every bit. On success, `mem_wr_en` is asserted in that cycle with `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata`. One cycle later, `rsp_valid` is 1 and `rsp_data` is 1.
- R4: A failing store-conditional asserts neither `mem_wr_en` nor `mem_rd_en`. One cycle later, `rsp_valid` is 1 and `rsp_data` is 0.
- R5: Every store-conditional, whether it succeeds or fails, clears the reservation. A second store-conditional without a new load-linked therefore fails.
- R6: A `ctx_switch` pulse clears the reservation. A store-conditional in the same cycle as the pulse fails.
- R7: `inv_valid` clears the reservation when `inv_addr` and the reserved address agree above the low log2(BLOCK_BYTES) bits. The low bits are ignored. An invalidation to another block has no effect. A store-conditional in the same cycle as a matching invalidation fails.
- R8: A load-linked replaces any earlier reservation. If a load-linked arrives in the same cycle as a matching invalidation or a context switch, the new reservation is kept.
- R9: The reserved code 2'b11 behaves as idle. It causes no memory access and no response, and it leaves the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | Request operation: 00 idle, 01 load-linked, 10 store-conditional, 11 reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store-conditional write data |
| inv_valid | input | 1 | Snooped invalidation present this cycle |
| inv_addr | input | ADDR_W | Address of the snooped invalidation |
| ctx_switch | input | 1 | Context-switch pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the read cycle |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Loaded word, or success flag for a store-conditional |

## Verification
The bench targets same-cycle collisions. It sends a store-conditional together with a matching invalidation or a context switch. A design that evaluated only the registered reservation would write memory there. It also sends a load-linked together with a matching invalidation, where a design with the wrong priority would lose the fresh reservation and fail the following store. Invalidations that differ only in the offset bits, and invalidations to a neighbouring block, catch a comparison that uses the wrong slice. Back-to-back store-conditionals and the reserved opcode catch a reservation that is not consumed, or one that is disturbed by an idle code.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              ctx_switch,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [1:0] OP_LL = 2'b01;
  localparam logic [1:0] OP_SC = 2'b10;

  logic              link_valid;
  logic [ADDR_W-1:0] link_addr;

  wire is_ll   = (req_op == OP_LL);
  wire is_sc   = (req_op == OP_SC);
  wire inv_hit = inv_valid && ((inv_addr >> OFF_W) == (link_addr >> OFF_W));
  wire broken  = ctx_switch || inv_hit;
  wire sc_ok   = is_sc && link_valid && (link_addr == req_addr) && !broken;

  assign mem_rd_en = is_ll;
  assign mem_wr_en = sc_ok;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_addr  <= '0;
    end else if (is_ll) begin
      link_valid <= 1'b1;
      link_addr  <= req_addr;
    end else if (is_sc || broken) begin
      link_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= is_ll || is_sc;
      rsp_data  <= is_ll ? mem_rdata : DATA_W'(sc_ok);
    end
  end

  assert_ll_reserves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == OP_LL) |=> (link_valid && link_addr == $past(req_addr)));

  assert_sc_write_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (rsp_valid && rsp_data == DATA_W'(1)));

  assert_sc_quiet_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_op == OP_SC) && !mem_wr_en) |=> (rsp_valid && rsp_data == '0));

  assert_sc_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);

  assert_ctx_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_switch && req_op != OP_LL) |=> !mem_wr_en);

  assert_no_rd_wr_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_idle_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 2'b11 || req_op == 2'b00) |=> !rsp_valid);
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, inv_addr = '0;
  logic        inv_valid = 1'b0, ctx_switch = 1'b0;
  logic        mem_rd_en, mem_wr_en, rsp_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_data;

  localparam logic [31:0] KEY = 32'h3C3C_A5A5;

  always #2 clk = ~clk;
  assign mem_rdata = mem_addr ^ KEY;

  llsc_monitor #(.ADDR_W(32), .DATA_W(32), .BLOCK_BYTES(16)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .ctx_switch(ctx_switch), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_valid = 0;
  logic [31:0] m_addr = '0;
  bit exp_rv = 0;
  logic [31:0] exp_rd = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd,
                      input bit inv, input logic [31:0] ia, input bit ctx, input string tag);
    bit inv_hit, sc_ok;
    @(negedge clk);
    check({tag, " rsp_valid"}, {31'b0, rsp_valid}, {31'b0, exp_rv});
    if (exp_rv) check({tag, " rsp_data"}, rsp_data, exp_rd);
    req_op = op; req_addr = a; req_wdata = wd;
    inv_valid = inv; inv_addr = ia; ctx_switch = ctx;
    #1;
    inv_hit = inv && m_valid && ((ia >> 4) == (m_addr >> 4));
    sc_ok = (op == 2'b10) && m_valid && (a == m_addr) && !ctx && !inv_hit;
    check({tag, " mem_rd_en"}, {31'b0, mem_rd_en}, {31'b0, op == 2'b01});
    check({tag, " mem_wr_en"}, {31'b0, mem_wr_en}, {31'b0, sc_ok});
    if (op == 2'b01 || sc_ok) check({tag, " mem_addr"}, mem_addr, a);
    if (sc_ok) check({tag, " mem_wdata"}, mem_wdata, wd);
    exp_rv = (op == 2'b01) || (op == 2'b10);
    exp_rd = (op == 2'b01) ? (a ^ KEY) : {31'b0, sc_ok};
    if (op == 2'b01) begin m_valid = 1; m_addr = a; end
    else if (op == 2'b10 || ctx || inv_hit) m_valid = 0;
  endtask

  task automatic idle(string tag);
    step(2'b00, 32'h0, 32'h0, 0, 32'h0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 mem_rd_en", {31'b0, mem_rd_en}, 32'h0);
    check("R1 mem_wr_en", {31'b0, mem_wr_en}, 32'h0);
    rst_n = 1'b1;
    idle("R1");
    step(2'b10, 32'h40, 32'h11, 0, 0, 0, "R1 sc_after_reset");
    // R2 / R3 basic pair, R5 second SC fails
    step(2'b01, 32'h44, 0, 0, 0, 0, "R2 ll");
    step(2'b10, 32'h44, 32'hDEAD_BEEF, 0, 0, 0, "R3 sc_ok");
    step(2'b10, 32'h44, 32'h22, 0, 0, 0, "R5 second_sc");
    // R3 address mismatch within block, R4
    step(2'b01, 32'h48, 0, 0, 0, 0, "R2 ll");
    step(2'b10, 32'h4C, 32'h33, 0, 0, 0, "R4 sc_mismatch");
    // R7 invalidation same block, offset differs
    step(2'b01, 32'h50, 0, 0, 0, 0, "R2 ll");
    step(2'b00, 0, 0, 1, 32'h5F, 0, "R7 inv_same_block");
    step(2'b10, 32'h50, 32'h44, 0, 0, 0, "R7 sc_after_inv");
    // R7 invalidation other block
    step(2'b01, 32'h50, 0, 0, 0, 0, "R2 ll");
    step(2'b00, 0, 0, 1, 32'h60, 0, "R7 inv_other_block");
    step(2'b10, 32'h50, 32'h55, 0, 0, 0, "R7 sc_survives");
    // R7 same-cycle SC and matching invalidation
    step(2'b01, 32'h50, 0, 0, 0, 0, "R2 ll");
    step(2'b10, 32'h50, 32'h66, 1, 32'h54, 0, "R7 sc_with_inv");
    // R6 context switch
    step(2'b01, 32'h40, 0, 0, 0, 0, "R2 ll");
    step(2'b00, 0, 0, 0, 0, 1, "R6 ctx");
    step(2'b10, 32'h40, 32'h77, 0, 0, 0, "R6 sc_after_ctx");
    step(2'b01, 32'h40, 0, 0, 0, 0, "R2 ll");
    step(2'b10, 32'h40, 32'h78, 0, 0, 1, "R6 sc_with_ctx");
    // R8 overwrite and priority
    step(2'b01, 32'h40, 0, 0, 0, 0, "R8 ll_a");
    step(2'b01, 32'h58, 0, 0, 0, 0, "R8 ll_b");
    step(2'b10, 32'h40, 32'h88, 0, 0, 0, "R8 sc_old");
    step(2'b01, 32'h40, 0, 0, 0, 0, "R8 ll_a");
    step(2'b01, 32'h58, 0, 0, 0, 0, "R8 ll_b");
    step(2'b10, 32'h58, 32'h89, 0, 0, 0, "R8 sc_new");
    step(2'b01, 32'h44, 0, 1, 32'h40, 1, "R8 ll_with_inv_ctx");
    step(2'b10, 32'h44, 32'h8A, 0, 0, 0, "R8 sc_after_collision");
    // R9 reserved code
    step(2'b01, 32'h4C, 0, 0, 0, 0, "R2 ll");
    step(2'b11, 32'h4C, 32'h99, 0, 0, 0, "R9 reserved");
    step(2'b11, 32'h40, 32'h9A, 0, 0, 0, "R9 reserved");
    step(2'b10, 32'h4C, 32'h9B, 0, 0, 0, "R9 sc_after_reserved");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      int r;
      r = $urandom_range(0, 9);
      op = (r < 4) ? 2'b01 : (r < 8) ? 2'b10 : 2'(r - 8) == 0 ? 2'b00 : 2'b11;
      step(op, 32'h40 + 32'($urandom_range(0, 7)) * 4, $urandom,
           ($urandom_range(0, 5) == 0), 32'h40 + 32'($urandom_range(0, 31)),
           ($urandom_range(0, 9) == 0), "R3 R7 R8 mixed");
    end
    idle("R4 drain");
    idle("R4 drain");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule